// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Registers

This block keeps time of day and calendar date as packed BCD counters and shows them to a host as the eight highest bytes of a byte-wide memory space. The host never sees the counters directly: it reads and writes a bank of seven shadow registers that the counters refresh once per second, plus a control byte. A one-cycle pulse on the tick input marks each second boundary; the oscillator, divider and calibration logic live outside this block.

Software that wants a consistent snapshot sets the read-halt bit, reads the time bytes at leisure and clears the bit again; the counters keep running meanwhile. Software that wants to set the clock sets the write-halt bit, writes the seven time bytes and clears the bit, which copies the shadow bank into the counters in one cycle. A stop flag, held in the top bit of the seconds byte, freezes timekeeping.

Halt handling is a three-state machine. `ST_RUN` refreshes the shadow bank on the cycle after each tick. `ST_RD_HOLD` is entered by writing the control byte with the read-halt bit set and the write-halt bit clear; it returns to `ST_RUN` when the read-halt bit is written back to 0. `ST_WR_HOLD` is entered from either of the other states by any control write with the write-halt bit set. It is left by a control write with that bit clear, which issues the load pulse and goes to `ST_RD_HOLD` if the same write sets read-halt, otherwise to `ST_RUN`.

Top module: `calendar_clock`

## Requirements
- R1: The window is the eight addresses whose upper address bits equal the upper bits of `WIN_BASE` (default 0x7F8 to 0x7FF). Low address bits 0 to 7 select control, seconds, minutes, hours, weekday, date, month and year in that order. Read data appears on `bus_rdata` one cycle after a read strobe. A read outside the window returns 0x00, and a write outside the window changes nothing.
- R2: The control byte reads back as written: bit 7 is write-halt, bit 6 is read-halt, bit 5 is the calibration sign and bits 4:0 are the calibration magnitude.
- R3: Bits that have no function read as zero. Seconds and minutes keep bits 6:0, hours and date keep bits 5:0, and month keeps bits 4:0. The weekday byte keeps bits 2:0 for the day and bit 6 as a stored test flag. Seconds bit 7 reads the stop flag.
- R4: After reset the time reads 00:00:00, weekday 01, date 01, month 01, year 00. The stop flag is 1, so seconds reads 0x80, and the control byte is 0x00.
- R5: Each tick advances seconds. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00, each carrying into the next field.
- R6: On the hour carry the weekday advances and wraps from 7 to 1. The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other long months.
- R7: February ends after 29 when the year's two-digit value is divisible by 4, with 00 counted as a leap year. Otherwise it ends after 28.
- R8: Month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R9: While read-halt is set, the shadow bank does not change except by host writes, and the counters keep counting. After read-halt clears, the first tick refreshes the shadow bank with the current count.
- R10: While write-halt is set, ticks do not alter the shadow bank. A control write that clears write-halt copies all seven shadow bytes into the counters.
- R11: A refresh copies all seven fields in the same cycle. A halt written in the cycle that a refresh is due does not cancel that refresh.
- R12: Writing 1 to seconds bit 7 stops the counters from advancing. Writing 0 there lets the next tick advance them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after a read strobe |

## Verification
The hardest situation to reach is a halt written in the very cycle that a refresh is due. The refresh is due one cycle after the tick, so there is a single-cycle window. The stimulus drops the tick pulse and puts the read-halt write on the bus at the next falling edge, so that the write and the pending refresh meet at the same clock edge. The shadow bank must then show the advanced count and stay frozen through later ticks. Calendar boundaries that would take days of ticks are reached by loading near-boundary values through write-halt and issuing one tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SLOT_N = 8;
    localparam int unsigned IDX_W  = $clog2(SLOT_N);

    typedef enum logic [IDX_W-1:0] {
        SLOT_CTRL = 3'd0, SLOT_SEC  = 3'd1, SLOT_MIN  = 3'd2, SLOT_HOUR = 3'd3,
        SLOT_WDAY = 3'd4, SLOT_DATE = 3'd5, SLOT_MON  = 3'd6, SLOT_YEAR = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RD_HOLD = 2'd1,
        ST_WR_HOLD = 2'd2
    } halt_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] wday;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] year;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         wday: 8'h01, date: 8'h01, mon: 8'h01,
                                         year: 8'h00};

    // bits kept in the shadow byte of each time slot
    function automatic logic [BYTE_W-1:0] slot_mask(input int k);
        case (k)
            1, 2:    return 8'h7F;
            3, 5:    return 8'h3F;
            4:       return 8'h07;
            6:       return 8'h1F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // {wrap, next}: advance a BCD value, wrapping to first after last
    function automatic logic [BYTE_W:0] bcd_step(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] last,
                                                 input logic [BYTE_W-1:0] first);
        if (v >= last)
            return {1'b1, first};
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [BYTE_W-1:0] yr);
        logic [BYTE_W-1:0] bin;
        bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [BYTE_W-1:0] month_last(input logic [BYTE_W-1:0] mon,
                                                     input logic [BYTE_W-1:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t cur_i,
    output cal_time_t nxt_o
);
    logic [BYTE_W:0] s_sec, s_min, s_hour, s_wday, s_date, s_mon, s_year;
    logic [BYTE_W-1:0] date_last;

    always_comb begin
        date_last = month_last(cur_i.mon, cur_i.year);
        s_sec  = bcd_step(cur_i.sec, 8'h59, 8'h00);
        s_min  = s_sec[BYTE_W]  ? bcd_step(cur_i.min, 8'h59, 8'h00) : {1'b0, cur_i.min};
        s_hour = s_min[BYTE_W]  ? bcd_step(cur_i.hour, 8'h23, 8'h00) : {1'b0, cur_i.hour};
        s_wday = s_hour[BYTE_W] ? bcd_step(cur_i.wday, 8'h07, 8'h01) : {1'b0, cur_i.wday};
        s_date = s_hour[BYTE_W] ? bcd_step(cur_i.date, date_last, 8'h01) : {1'b0, cur_i.date};
        s_mon  = s_date[BYTE_W] ? bcd_step(cur_i.mon, 8'h12, 8'h01) : {1'b0, cur_i.mon};
        s_year = s_mon[BYTE_W]  ? bcd_step(cur_i.year, 8'h99, 8'h00) : {1'b0, cur_i.year};

        nxt_o.sec  = s_sec[BYTE_W-1:0];
        nxt_o.min  = s_min[BYTE_W-1:0];
        nxt_o.hour = s_hour[BYTE_W-1:0];
        nxt_o.wday = s_wday[BYTE_W-1:0];
        nxt_o.date = s_date[BYTE_W-1:0];
        nxt_o.mon  = s_mon[BYTE_W-1:0];
        nxt_o.year = s_year[BYTE_W-1:0];
    end

    // s_year wrap bit is intentionally dropped: the century is not kept
    logic unused_wrap;
    assign unused_wrap = s_year[BYTE_W] ^ s_wday[BYTE_W];
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      load_i,
    input  cal_time_t load_val_i,
    input  logic      stop_wr_i,
    input  logic      stop_val_i,
    output cal_time_t cnt_o,
    output logic      stop_o
);
    cal_time_t cnt_q, cnt_nxt;
    logic      stop_q;

    cal_advance u_adv (
        .cur_i (cnt_q),
        .nxt_o (cnt_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= TIME_RESET;
            stop_q <= 1'b1;
        end else begin
            if (load_i)
                cnt_q <= load_val_i;
            else if (tick_i && !stop_q)
                cnt_q <= cnt_nxt;
            if (stop_wr_i)
                stop_q <= stop_val_i;
        end
    end

    assign cnt_o  = cnt_q;
    assign stop_o = stop_q;

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !load_i) |=> $stable(cnt_q)); // R12
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R10
    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              refresh_due_i,
    input  cal_time_t         cnt_i,
    input  logic              stop_i,
    output logic              load_o,
    output cal_time_t         load_val_o,
    output logic [BYTE_W-1:0] rd_byte_o
);
    localparam int unsigned WBIT = BYTE_W - 1;
    localparam int unsigned RBIT = BYTE_W - 2;
    localparam logic [$bits(cal_time_t)-1:0] RST_FLAT = TIME_RESET;

    halt_state_e       state_q, state_d;
    logic [BYTE_W-1:0] ctrl_q;
    logic              ft_q;
    logic [BYTE_W-1:0] shadow_q [1:SLOT_N-1];
    logic              ctrl_wr, time_wr, refresh;
    logic [$bits(cal_time_t)-1:0] cnt_flat, shadow_flat;

    assign ctrl_wr  = wr_i && (idx_i == SLOT_CTRL);
    assign time_wr  = wr_i && (idx_i != SLOT_CTRL);
    assign cnt_flat = cnt_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctrl_wr && wdata_i[WBIT])      state_d = ST_WR_HOLD;
                else if (ctrl_wr && wdata_i[RBIT]) state_d = ST_RD_HOLD;
            end
            ST_RD_HOLD: begin
                if (ctrl_wr && wdata_i[WBIT])       state_d = ST_WR_HOLD;
                else if (ctrl_wr && !wdata_i[RBIT]) state_d = ST_RUN;
            end
            ST_WR_HOLD: begin
                if (ctrl_wr && !wdata_i[WBIT])
                    state_d = wdata_i[RBIT] ? ST_RD_HOLD : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load_o  = 1'b0;
        refresh = 1'b0;
        unique case (state_q)
            ST_RUN:     refresh = refresh_due_i;
            ST_WR_HOLD: load_o  = ctrl_wr && !wdata_i[WBIT];
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ft_q   <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= wdata_i;
            if (wr_i && idx_i == SLOT_WDAY)
                ft_q <= wdata_i[6];
        end
    end

    // one shadow byte per time slot; a refresh beats a host write
    for (genvar k = 1; k < SLOT_N; k++) begin : g_slot
        localparam int unsigned LSB = (SLOT_N - 1 - k) * BYTE_W;
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[k] <= RST_FLAT[LSB +: BYTE_W];
            else if (refresh)
                shadow_q[k] <= cnt_flat[LSB +: BYTE_W];
            else if (wr_i && idx_i == IDX_W'(k))
                shadow_q[k] <= wdata_i & slot_mask(k);
        end
        assign shadow_flat[LSB +: BYTE_W] = shadow_q[k];
    end

    assign load_val_o = shadow_flat;

    always_comb begin
        unique case (idx_i)
            SLOT_CTRL: rd_byte_o = ctrl_q;
            SLOT_SEC:  rd_byte_o = {stop_i, shadow_q[1][6:0]};
            SLOT_WDAY: rd_byte_o = {1'b0, ft_q, 3'b000, shadow_q[4][2:0]};
            default:   rd_byte_o = shadow_q[idx_i];
        endcase
    end

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !time_wr) |=> $stable(shadow_flat)); // R9
    AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (shadow_flat == $past(cnt_flat))); // R11
    AST_WR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata_i[WBIT]) |=> (state_q == ST_WR_HOLD)); // R10
endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
    import cal_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 11'h7F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic              in_win, hit_wr, hit_rd, tick_d, load, stop;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] rd_byte;
    cal_time_t         cnt, load_val;

    assign in_win = (bus_addr[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);
    assign idx    = bus_addr[IDX_W-1:0];
    assign hit_wr = bus_sel && bus_wr && in_win;
    assign hit_rd = bus_sel && !bus_wr && in_win;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_d    <= 1'b0;
            bus_rdata <= '0;
        end else begin
            tick_d    <= tick_1hz;
            bus_rdata <= hit_rd ? rd_byte : '0;
        end
    end

    cal_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_1hz),
        .load_i     (load),
        .load_val_i (load_val),
        .stop_wr_i  (hit_wr && idx == SLOT_SEC),
        .stop_val_i (bus_wdata[BYTE_W-1]),
        .cnt_o      (cnt),
        .stop_o     (stop)
    );

    cal_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (hit_wr),
        .idx_i         (idx),
        .wdata_i       (bus_wdata),
        .refresh_due_i (tick_d),
        .cnt_i         (cnt),
        .stop_i        (stop),
        .load_o        (load),
        .load_val_o    (load_val),
        .rd_byte_o     (rd_byte)
    );

    AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !in_win) |=> (bus_rdata == '0)); // R1
endmodule

// File: tb/sim_calendar_clock.sv
module sim_calendar_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, tick = 1'b0, sel = 1'b0, wr = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rd_pend = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    localparam logic [10:0] A_CTRL = 11'h7F8, A_SEC = 11'h7F9, A_MIN = 11'h7FA,
                            A_HOUR = 11'h7FB, A_WDAY = 11'h7FC, A_DATE = 11'h7FD,
                            A_MON = 11'h7FE, A_YEAR = 11'h7FF;

    always #4 clk = ~clk;

    calendar_clock u0 (
        .clk (clk), .rst_n (rst_n), .tick_1hz (tick), .bus_sel (sel), .bus_wr (wr),
        .bus_addr (addr), .bus_wdata (wdata), .bus_rdata (rdata)
    );

    // monitor: a read strobe seen at an edge yields data at the next falling edge
    always @(posedge clk) rd_pend <= rst_n && sel && !wr;

    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: got %02h expected %02h", t, rdata, e);
            end
        end
    end

    // all tasks start and end at a falling edge
    task automatic do_wr(input logic [10:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic do_rd(input logic [10:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] wd, input logic [7:0] dt,
                             input logic [7:0] mo, input logic [7:0] y);
        do_wr(A_CTRL, 8'h80);
        do_wr(A_SEC, s);  do_wr(A_MIN, m);  do_wr(A_HOUR, h);
        do_wr(A_WDAY, wd); do_wr(A_DATE, dt); do_wr(A_MON, mo); do_wr(A_YEAR, y);
        do_wr(A_CTRL, 8'h00);
    endtask

    task automatic read_date(input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                             input logic [7:0] y, input string t);
        do_rd(A_WDAY, wd, t); do_rd(A_DATE, dt, t); do_rd(A_MON, mo, t); do_rd(A_YEAR, y, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        do_rd(A_CTRL, 8'h00, "R4"); do_rd(A_SEC, 8'h80, "R4"); do_rd(A_MIN, 8'h00, "R4");
        do_rd(A_HOUR, 8'h00, "R4");
        read_date(8'h01, 8'h01, 8'h01, 8'h00, "R4");
        // R1 outside window: read zero, write ignored
        do_wr(11'h3F9, 8'h45);
        do_rd(11'h3F9, 8'h00, "R1");
        do_rd(A_SEC, 8'h80, "R1");

        // R12 stopped at reset: tick does nothing
        do_tick();
        do_rd(A_SEC, 8'h80, "R12");
        do_wr(A_SEC, 8'h00);
        repeat (3) do_tick();
        do_rd(A_SEC, 8'h03, "R5");

        // R9 read halt
        do_wr(A_CTRL, 8'h40);
        do_rd(A_CTRL, 8'h40, "R2");
        repeat (2) do_tick();
        do_rd(A_SEC, 8'h03, "R9");
        do_wr(A_CTRL, 8'h00);
        do_rd(A_SEC, 8'h03, "R9");
        do_tick();
        do_rd(A_SEC, 8'h06, "R9");

        // R11 halt written in the cycle the refresh is due
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        do_wr(A_CTRL, 8'h40);
        do_rd(A_SEC, 8'h07, "R11");
        do_tick();
        do_rd(A_SEC, 8'h07, "R11");
        do_wr(A_CTRL, 8'h00);
        do_tick();
        do_rd(A_SEC, 8'h09, "R11");

        // R12 stop mid-run, then restart
        do_wr(A_SEC, 8'h80);
        do_rd(A_SEC, 8'h80, "R12");
        do_tick();
        do_rd(A_SEC, 8'h89, "R12");
        do_wr(A_SEC, 8'h09);
        do_tick();
        do_rd(A_SEC, 8'h10, "R12");

        // R10 / R3 write halt: ticks leave the shadow bank alone, masks apply
        do_wr(A_CTRL, 8'hBF);
        do_rd(A_CTRL, 8'hBF, "R2");
        do_wr(A_MIN, 8'hFF);  do_wr(A_HOUR, 8'hFF); do_wr(A_WDAY, 8'hFF);
        do_wr(A_DATE, 8'hFF); do_wr(A_MON, 8'hFF);
        do_tick();
        do_rd(A_MIN, 8'h7F, "R3"); do_rd(A_HOUR, 8'h3F, "R3"); do_rd(A_WDAY, 8'h47, "R3");
        do_rd(A_DATE, 8'h3F, "R3"); do_rd(A_MON, 8'h1F, "R3");
        do_wr(A_SEC, 8'h56); do_wr(A_MIN, 8'h34); do_wr(A_HOUR, 8'h12);
        do_wr(A_WDAY, 8'h45); do_wr(A_DATE, 8'h15); do_wr(A_MON, 8'h06); do_wr(A_YEAR, 8'h07);
        do_tick();
        do_rd(A_SEC, 8'h56, "R10");
        do_wr(A_CTRL, 8'h3F);
        do_rd(A_CTRL, 8'h3F, "R2");
        do_tick();
        do_rd(A_SEC, 8'h57, "R10"); do_rd(A_MIN, 8'h34, "R10"); do_rd(A_HOUR, 8'h12, "R10");
        read_date(8'h45, 8'h15, 8'h06, 8'h07, "R3");

        // R5 / R6 / R7 full rollover, non-leap February
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        do_tick();
        do_rd(A_SEC, 8'h00, "R5"); do_rd(A_MIN, 8'h00, "R5"); do_rd(A_HOUR, 8'h00, "R5");
        read_date(8'h01, 8'h01, 8'h03, 8'h23, "R7");
        // R7 leap year 24
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_tick();
        read_date(8'h04, 8'h29, 8'h02, 8'h24, "R7");
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        do_tick();
        read_date(8'h04, 8'h01, 8'h03, 8'h24, "R7");
        // R7 year 00 is leap
        load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        do_tick();
        read_date(8'h02, 8'h29, 8'h02, 8'h00, "R7");
        // R6 thirty-day month, and 30th of a long month
        load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h05);
        do_tick();
        read_date(8'h03, 8'h01, 8'h05, 8'h05, "R6");
        load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h05);
        do_tick();
        read_date(8'h03, 8'h31, 8'h05, 8'h05, "R6");
        // R8 end of year 99
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick();
        read_date(8'h01, 8'h01, 8'h01, 8'h00, "R8");
        do_rd(A_HOUR, 8'h00, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule